// File: doc/BRIEF.md
# Shared-Vector Interrupt Controller

This block gathers interrupt requests for a small 8-bit controller and reduces them to one request at a time for the core. Six peripheral sources, each gated by its own enable bit, share four maskable vectors. Two groups of external port pins, each pin gated by its own enable, form two external sources that feed vectors 1 and 2. A non-maskable input ranks above all of them. The core sees a vector index with a valid strobe. The index holds until the core acknowledges it, and the next request is chosen after that.

A write-only option byte sets three things: the global enable, whether the first external source is edge- or level-sensed, and which edge of the second external source is active. External pins pass through a two-flop synchronizer. In edge mode a detected edge is held as pending until the matching vector is acknowledged. A wake output tells the power controller that an enabled request is present. It never fires while the global enable is off, even for the non-maskable input.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the option byte is 00h, so `irq_valid` and `wake` stay 0 even when every peripheral request and enable is high.
- R2: The option byte is written only when `wr_en` is high and `wr_addr` equals C8h. A write to any other address changes nothing.
- R3: Only bits 6, 5 and 4 of the written byte take effect. A write of 8Fh leaves the global enable off.
- R4: With the global enable (bit 4) at 0, no maskable vector is presented, and the non-maskable input is still presented as index 0.
- R5: `wake` is 1 exactly when the global enable is 1 and the non-maskable input or any enabled, gated source is requesting. It stays 0 while the global enable is 0.
- R6: With bit 6 at 1, external source 1 is level-sensed. Its request follows the synchronized pins and drops two cycles after they fall, with nothing latched.
- R7: With bit 6 at 0, a rising edge on external source 1 sets a pending request for vector 1. The pending request survives after the pin pulse ends and is cleared by the acknowledge of vector 1.
- R8: External source 2 is edge-sensed. Bit 5 at 1 makes a rising edge active and bit 5 at 0 makes a falling edge active. The other edge raises no request.
- R9: `per_req`/`per_mask` bit positions: 0 timer overflow and 1 conversion done go to vector 4; 2 reload-timer overflow, 3 compare match and 4 capture edge go to vector 3; 5 serial transfer done goes to vector 2. A source counts only when its mask bit is 1.
- R10: Among waiting requests the order is: non-maskable (index 0) first, then vector 1, 2, 3, 4.
- R11: A presented index is held with `irq_valid` high until `irq_ack`. It is dropped on the acknowledging edge, and a new choice appears one edge later.
- R12: A pin takes part in its external source only when its bit in the matching enable input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| nmi | input | 1 | Non-maskable request, level |
| per_req | input | 6 | Peripheral request flags |
| per_mask | input | 6 | Peripheral enable bits |
| grp1_pins | input | G1_W | External source 1 pins |
| grp1_en | input | G1_W | External source 1 pin enables |
| grp2_pins | input | G2_W | External source 2 pins |
| grp2_en | input | G2_W | External source 2 pin enables |
| irq_ack | input | 1 | Acknowledge of the presented index |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | 3 | Presented index: 0 non-maskable, 1..4 vectors |
| wake | output | 1 | Wake-up request |

## Verification
The `nmi` and peripheral inputs reach `wake` combinationally, in the same cycle. They reach `irq_valid`/`irq_vec` on the first rising edge. A pin change is seen by `wake` after two edges and by the index after three. An option write takes effect on the edge after the write edge. The bench drives every input on a falling edge, counts the rising edges for each path exactly, and samples on the next falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam logic [7:0] OPT_ADDR     = 8'hC8;
    localparam int         OPT_LVL1_BIT = 6;
    localparam int         OPT_POL2_BIT = 5;
    localparam int         OPT_GEN_BIT  = 4;

    localparam int NUM_PER = 6;
    localparam int PER_TMR = 0;
    localparam int PER_ADC = 1;
    localparam int PER_ARO = 2;
    localparam int PER_ARC = 3;
    localparam int PER_ARE = 4;
    localparam int PER_SPI = 5;

    typedef enum logic [2:0] {
        VEC_NMI = 3'd0,
        VEC_1   = 3'd1,
        VEC_2   = 3'd2,
        VEC_3   = 3'd3,
        VEC_4   = 3'd4
    } vec_e;

    typedef struct packed {
        logic lvl1;
        logic pol2;
        logic gen;
    } opt_t;

    function automatic opt_t decode_opt(input logic [7:0] d);
        opt_t o;
        o.lvl1 = d[OPT_LVL1_BIT];
        o.pol2 = d[OPT_POL2_BIT];
        o.gen  = d[OPT_GEN_BIT];
        return o;
    endfunction

    // returns {vec4, vec3, vec2} contributions of the gated peripherals
    function automatic logic [2:0] per_fold(input logic [NUM_PER-1:0] g);
        logic [2:0] v;
        v[0] = g[PER_SPI];
        v[1] = g[PER_ARO] | g[PER_ARC] | g[PER_ARE];
        v[2] = g[PER_TMR] | g[PER_ADC];
        return v;
    endfunction
endpackage

// File: rtl/irq_extsrc.sv
module irq_extsrc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] en,
    input  logic         level_mode,
    input  logic         active_high,
    input  logic         clr,
    output logic         req
);
    logic s1, s2, s3, pend;
    logic gated, edge_hit;

    assign gated    = |(pins & en);
    assign edge_hit = (s2 != s3) && (s2 == active_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s3   <= 1'b0;
            pend <= 1'b0;
        end else begin
            s1 <= gated;
            s2 <= s1;
            s3 <= s2;
            if (level_mode) pend <= 1'b0;
            else            pend <= edge_hit | (pend & ~clr);
        end
    end

    always_comb begin
        if (level_mode) req = (s2 == active_high);
        else            req = pend | edge_hit;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !edge_hit) |=> !pend); // R7
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       nmi,
    input  logic       gen,
    input  logic [3:0] vreq,
    input  logic       ack,
    output logic       valid,
    output vec_e       vec
);
    logic any_cand;
    vec_e cand;

    always_comb begin
        any_cand = 1'b1;
        cand     = VEC_NMI;
        if (nmi)                cand = VEC_NMI;
        else if (gen && vreq[0]) cand = VEC_1;
        else if (gen && vreq[1]) cand = VEC_2;
        else if (gen && vreq[2]) cand = VEC_3;
        else if (gen && vreq[3]) cand = VEC_4;
        else                    any_cand = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            vec   <= VEC_NMI;
        end else if (valid) begin
            if (ack) valid <= 1'b0;
        end else if (any_cand) begin
            valid <= 1'b1;
            vec   <= cand;
        end
    end

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(vec))); // R11
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!valid && nmi) |=> (valid && vec == VEC_NMI)); // R10
    AST_GEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!valid && !gen) |=> (!valid || vec == VEC_NMI)); // R4
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int G1_W = 8,
    parameter int G2_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                nmi,
    input  logic [NUM_PER-1:0]  per_req,
    input  logic [NUM_PER-1:0]  per_mask,
    input  logic [G1_W-1:0]     grp1_pins,
    input  logic [G1_W-1:0]     grp1_en,
    input  logic [G2_W-1:0]     grp2_pins,
    input  logic [G2_W-1:0]     grp2_en,
    input  logic                irq_ack,
    output logic                irq_valid,
    output logic [2:0]          irq_vec,
    output logic                wake
);
    opt_t       opt;
    logic       ext1_req, ext2_req, clr1, clr2;
    logic [2:0] per_v;
    logic [3:0] vreq;
    vec_e       vec_q;

    always_ff @(posedge clk) begin
        if (rst)                                opt <= '0;
        else if (wr_en && wr_addr == OPT_ADDR)  opt <= decode_opt(wr_data);
    end

    assign clr1 = irq_valid && irq_ack && (vec_q == VEC_1);
    assign clr2 = irq_valid && irq_ack && (vec_q == VEC_2);

    irq_extsrc #(.W(G1_W)) u_ext1 (
        .clk(clk), .rst(rst), .pins(grp1_pins), .en(grp1_en),
        .level_mode(opt.lvl1), .active_high(1'b1), .clr(clr1), .req(ext1_req)
    );

    irq_extsrc #(.W(G2_W)) u_ext2 (
        .clk(clk), .rst(rst), .pins(grp2_pins), .en(grp2_en),
        .level_mode(1'b0), .active_high(opt.pol2), .clr(clr2), .req(ext2_req)
    );

    assign per_v = per_fold(per_req & per_mask);
    assign vreq  = {per_v[2], per_v[1], per_v[0] | ext2_req, ext1_req};

    irq_pick u_pick (
        .clk(clk), .rst(rst), .nmi(nmi), .gen(opt.gen), .vreq(vreq),
        .ack(irq_ack), .valid(irq_valid), .vec(vec_q)
    );

    assign irq_vec = vec_q;
    assign wake    = opt.gen && (nmi || (|vreq));

    AST_NO_WAKE_OFF: assert property (@(posedge clk) disable iff (rst)
        !opt.gen |-> !wake); // R5
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vec <= 3'd4)); // R9
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!irq_valid && !wake)); // R1
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       nmi = 1'b0;
    logic [5:0] per_req = '0, per_mask = '0;
    logic [7:0] g1p = '0, g1e = '0, g2p = '0, g2e = '0;
    logic       ack = 1'b0;
    logic       irq_valid, wake;
    logic [2:0] irq_vec;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .nmi(nmi), .per_req(per_req), .per_mask(per_mask),
        .grp1_pins(g1p), .grp1_en(g1e), .grp2_pins(g2p), .grp2_en(g2e),
        .irq_ack(ack), .irq_valid(irq_valid), .irq_vec(irq_vec), .wake(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_opt(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    // expected index from the requirements: returns -1 when nothing is due
    function automatic int exp_pick(input logic n, input logic g, input logic [5:0] r, input logic [5:0] m);
        logic [5:0] e;
        e = r & m;
        if (n) return 0;
        if (!g) return -1;
        if (e[5]) return 2;
        if (e[2] || e[3] || e[4]) return 3;
        if (e[0] || e[1]) return 4;
        return -1;
    endfunction

    function automatic int exp_wake(input logic n, input logic g, input logic [5:0] r, input logic [5:0] m);
        return (g && (n || ((r & m) != 0))) ? 1 : 0;
    endfunction

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int e;
        void'($urandom(32'h1234_5678));
        per_req = '1; per_mask = '1;
        tick(3);
        rst = 1'b0;
        tick(2);
        check("R1", "valid after reset", irq_valid, 0);
        check("R1", "wake after reset", wake, 0);

        write_opt(8'hC9, 8'h10);
        tick(2);
        check("R2", "valid after write elsewhere", irq_valid, 0);

        write_opt(8'hC8, 8'h8F);
        tick(2);
        check("R3", "valid after unused bits", irq_valid, 0);
        check("R3", "wake after unused bits", wake, 0);

        nmi = 1'b1;
        tick(1);
        check("R4", "nmi valid with gen off", irq_valid, 1);
        check("R4", "nmi index", irq_vec, 0);
        check("R5", "no wake with gen off", wake, 0);
        nmi = 1'b0;
        do_ack();
        check("R4", "maskables blocked", irq_valid, 0);
        per_req = '0;

        write_opt(8'hC8, 8'h10);
        per_req = 6'b000001;
        tick(1);
        check("R9", "timer on vec4 valid", irq_valid, 1);
        check("R9", "timer on vec4", irq_vec, 4);
        check("R5", "wake with gen on", wake, 1);
        per_req = 6'b100001;
        tick(2);
        check("R11", "held index", irq_vec, 4);
        do_ack();
        check("R11", "dropped on ack", irq_valid, 0);
        tick(1);
        check("R11", "next choice", irq_vec, 2);
        check("R10", "spi valid", irq_valid, 1);
        per_req = '0;
        do_ack();

        per_req = '1; nmi = 1'b1;
        tick(1);
        check("R10", "nmi over all", irq_vec, 0);
        per_req = '0; nmi = 1'b0;
        do_ack();

        for (int i = 0; i < 40; i++) begin
            per_req  = 6'($urandom);
            per_mask = 6'($urandom);
            nmi      = ($urandom % 4) == 0;
            e = exp_pick(nmi, 1'b1, per_req, per_mask);
            tick(1);
            check("R10", "random valid", irq_valid, (e >= 0) ? 1 : 0);
            if (e >= 0) check("R9", "random index", irq_vec, e);
            check("R5", "random wake", wake, exp_wake(nmi, 1'b1, per_req, per_mask));
            per_req = '0; nmi = 1'b0;
            do_ack();
            check("R11", "random cleared", irq_valid, 0);
        end
        per_mask = '1;

        g1e = 8'h01;
        g1p = 8'h01;
        tick(1);
        g1p = 8'h00;
        tick(1);
        check("R7", "edge wake", wake, 1);
        tick(1);
        check("R7", "edge latched valid", irq_valid, 1);
        check("R7", "edge index", irq_vec, 1);
        do_ack();
        tick(1);
        check("R7", "pending cleared", irq_valid, 0);
        check("R7", "no wake after clear", wake, 0);

        g1e = 8'h00;
        g1p = 8'h01;
        tick(4);
        check("R12", "disabled pin valid", irq_valid, 0);
        check("R12", "disabled pin wake", wake, 0);
        g1p = 8'h00;
        g1e = 8'h01;
        tick(4);

        write_opt(8'hC8, 8'h50);
        g1p = 8'h01;
        tick(2);
        check("R6", "level wake", wake, 1);
        tick(1);
        check("R6", "level index", irq_vec, 1);
        g1p = 8'h00;
        tick(2);
        check("R6", "level not latched", wake, 0);
        check("R11", "held while level gone", irq_valid, 1);
        do_ack();
        tick(1);
        check("R6", "nothing after level drop", irq_valid, 0);

        write_opt(8'hC8, 8'h30);
        g2e = 8'h01;
        g2p = 8'h01;
        tick(3);
        check("R8", "rising accepted", irq_valid, 1);
        check("R8", "rising index", irq_vec, 2);
        do_ack();
        tick(1);
        check("R8", "cleared", irq_valid, 0);
        g2p = 8'h00;
        tick(4);
        check("R8", "falling ignored", irq_valid, 0);
        write_opt(8'hC8, 8'h10);
        g2p = 8'h01;
        tick(4);
        check("R8", "rising ignored", irq_valid, 0);
        g2p = 8'h00;
        tick(3);
        check("R8", "falling accepted", irq_vec, 2);
        check("R8", "falling valid", irq_valid, 1);
        do_ack();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule